// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block sits beside the instruction pipeline and decides, once per cycle, whether a pending synchronous exception or an external interrupt is accepted. When one is accepted, it performs the whole handler entry in a single clock edge. The current status word, R15 and the return address are saved. The status word is then forced into privileged, alternate-bank, blocked mode. The event code register matching the kind of entry is loaded, and the program counter is redirected to the right handler address. A one-cycle strobe then tells the pipeline to flush.

The block also drives the current interrupt mask to an external interrupt controller. That controller answers with a hit flag and a 12-bit vector code. Delay-slot state comes in as flags. When the trapping instruction sat in a delay slot, the saved return address is pulled back to the branch so that the branch executes again.

The controller has two states. `ST_RUN` evaluates requests each cycle. The transition `RUN->ENTRY` fires when an entry is accepted, and it loads all saved registers on that edge. `ST_ENTRY` raises the taken strobe and ignores all requests. The transition `ENTRY->RUN` is unconditional. The synchronous reset input forces `ST_RUN` with the power-on register values.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and an interrupt are both requested in the same RUN cycle, the exception is taken. The interrupt event register is left unchanged.
- R2: When status bit 28 (block) is set, any exception whose code is not 0x1E0 is taken as a reset with event code 0x000. Code 0x1E0 is taken normally.
- R3: `irq_mask_o` always equals status bits [7:4]. An interrupt is not taken when the block bit is set or when the controller reports no hit (`icu_hit_i`=0).
- R4: On any entry, SSR receives the incoming status and SGR receives R15. The new status equals the incoming status with bits 30 (privileged), 29 (register bank) and 28 (block) set.
- R5: On an exception, the exception event register is loaded with the effective code with bit 11 cleared (code AND 0x7FF).
- R6: Reset-class exceptions (codes 0x000 and 0x020) set status bits [7:4] to 0xF and load PC with 0xA0000000.
- R7: TLB-miss codes 0x040 and 0x060 enter at VBR+0x400. All other non-reset exceptions enter at VBR+0x100.
- R8: An accepted interrupt enters at VBR+0x600 and loads the interrupt event register with the controller's vector code. The exception event register is left unchanged.
- R9: For the trap-instruction code 0x160, the saved PC is the incoming PC plus 2.
- R10: If either delay-slot flag is set, the saved PC is the incoming PC minus 2 before any trap adjustment. `dsf_o` is 0 after an entry and otherwise follows `dsf_i` one cycle later.
- R11: An accepted request updates all registers on the next edge, and `taken_o` is then high for exactly one cycle. Requests seen while `taken_o` is high are ignored.
- R12: Synchronous reset gives SR=0x700000F0, PC=0xA0000000, zero in SSR, SPC, SGR and both event registers, and `taken_o`=0.
- R13: With no exception and no accepted interrupt, all outputs hold and `taken_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_valid_i | input | 1 | Exception pending |
| exc_code_i | input | CODE_W | Exception event code |
| irq_req_i | input | 1 | External interrupt request |
| irq_mask_o | output | 4 | Current interrupt mask sent to the controller |
| icu_hit_i | input | 1 | Controller has an interrupt above the mask |
| icu_code_i | input | CODE_W | Controller vector code |
| sr_i | input | DATA_W | Current status word |
| pc_i | input | DATA_W | PC of the instruction being interrupted |
| vbr_i | input | DATA_W | Vector base |
| r15_i | input | DATA_W | General register 15 |
| dsf_i | input | DSF_W | Delay-slot flags |
| taken_o | output | 1 | One-cycle entry strobe (flush) |
| sr_o | output | DATA_W | Updated status word |
| ssr_o | output | DATA_W | Saved status |
| spc_o | output | DATA_W | Saved PC |
| sgr_o | output | DATA_W | Saved R15 |
| expevt_o | output | CODE_W | Exception event register |
| intevt_o | output | CODE_W | Interrupt event register |
| pc_o | output | DATA_W | Handler PC |
| dsf_o | output | DSF_W | Delay-slot flags after entry handling |

## Verification
An exception and an interrupt can arrive in the same RUN cycle. The bench provokes this by raising both requests together, with the controller reporting a hit. It judges the outcome by the handler PC, which must be the general exception entry, and by the interrupt event register, which must keep its reset value. A second overlap is the block bit with an exception. Here the bench compares code 0x1E0 against an ordinary code to see which one is turned into a reset.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_EXC  = 2'd1,
        KIND_IRQ  = 2'd2
    } entry_kind_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ENTRY = 1'b1
    } seq_state_e;

    localparam int SR_MD_BIT = 30;
    localparam int SR_RB_BIT = 29;
    localparam int SR_BL_BIT = 28;
    localparam int MASK_LO   = 4;
    localparam int MASK_W    = 4;

    localparam logic [11:0] CODE_POWER  = 12'h000;
    localparam logic [11:0] CODE_MRESET = 12'h020;
    localparam logic [11:0] CODE_TLB_RD = 12'h040;
    localparam logic [11:0] CODE_TLB_WR = 12'h060;
    localparam logic [11:0] CODE_TRAP   = 12'h160;
    localparam logic [11:0] CODE_BREAK  = 12'h1E0;

    localparam logic [31:0] RESET_PC  = 32'hA000_0000;
    localparam logic [31:0] OFS_GEN   = 32'h0000_0100;
    localparam logic [31:0] OFS_TLB   = 32'h0000_0400;
    localparam logic [31:0] OFS_IRQ   = 32'h0000_0600;
    localparam logic [31:0] RESET_SR  = 32'h7000_00F0;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              run,
    input  logic              blocked,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              icu_hit,
    output entry_kind_e       kind,
    output logic [CODE_W-1:0] eff_code
);
    always_comb begin
        if (blocked && exc_code != CODE_W'(CODE_BREAK))
            eff_code = CODE_W'(CODE_POWER);
        else
            eff_code = exc_code;

        if (!run)
            kind = KIND_NONE;
        else if (exc_valid)
            kind = KIND_EXC;
        else if (irq_req && icu_hit && !blocked)
            kind = KIND_IRQ;
        else
            kind = KIND_NONE;
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 12,
    parameter int DSF_W  = 2
) (
    input  entry_kind_e       kind,
    input  logic [CODE_W-1:0] eff_code,
    input  logic [DATA_W-1:0] sr,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] vbr,
    input  logic [DSF_W-1:0]  dsf,
    output logic [DATA_W-1:0] new_sr,
    output logic [DATA_W-1:0] new_spc,
    output logic [DATA_W-1:0] new_pc,
    output logic [CODE_W-1:0] new_expevt
);
    localparam logic [DATA_W-1:0] ENTRY_BITS =
        (DATA_W'(1) << SR_MD_BIT) | (DATA_W'(1) << SR_RB_BIT) | (DATA_W'(1) << SR_BL_BIT);
    localparam logic [DATA_W-1:0] MASK_ALL = DATA_W'({MASK_W{1'b1}}) << MASK_LO;

    logic is_exc, is_reset, is_tlb, is_trap;
    logic [DATA_W-1:0] ret_base;

    always_comb begin
        is_exc   = (kind == KIND_EXC);
        is_reset = is_exc && (eff_code == CODE_W'(CODE_POWER) || eff_code == CODE_W'(CODE_MRESET));
        is_tlb   = (eff_code == CODE_W'(CODE_TLB_RD)) || (eff_code == CODE_W'(CODE_TLB_WR));
        is_trap  = is_exc && (eff_code == CODE_W'(CODE_TRAP));

        ret_base = (|dsf) ? pc - DATA_W'(2) : pc;
        new_spc  = is_trap ? ret_base + DATA_W'(2) : ret_base;

        new_sr   = sr | ENTRY_BITS | (is_reset ? MASK_ALL : '0);

        if (!is_exc)
            new_pc = vbr + DATA_W'(OFS_IRQ);
        else if (is_reset)
            new_pc = DATA_W'(RESET_PC);
        else if (is_tlb)
            new_pc = vbr + DATA_W'(OFS_TLB);
        else
            new_pc = vbr + DATA_W'(OFS_GEN);

        new_expevt = {1'b0, eff_code[CODE_W-2:0]};
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 12,
    parameter int DSF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    output logic [MASK_W-1:0] irq_mask_o,
    input  logic              icu_hit_i,
    input  logic [CODE_W-1:0] icu_code_i,
    input  logic [DATA_W-1:0] sr_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] vbr_i,
    input  logic [DATA_W-1:0] r15_i,
    input  logic [DSF_W-1:0]  dsf_i,
    output logic              taken_o,
    output logic [DATA_W-1:0] sr_o,
    output logic [DATA_W-1:0] ssr_o,
    output logic [DATA_W-1:0] spc_o,
    output logic [DATA_W-1:0] sgr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o,
    output logic [DATA_W-1:0] pc_o,
    output logic [DSF_W-1:0]  dsf_o
);
    seq_state_e        state_q, state_d;
    entry_kind_e       kind;
    logic [CODE_W-1:0] eff_code;
    logic [DATA_W-1:0] new_sr, new_spc, new_pc;
    logic [CODE_W-1:0] new_expevt;

    assign irq_mask_o = sr_i[MASK_LO +: MASK_W];
    assign taken_o    = (state_q == ST_ENTRY);

    exc_arbiter #(.CODE_W(CODE_W)) u_arb (
        .run       (state_q == ST_RUN),
        .blocked   (sr_i[SR_BL_BIT]),
        .exc_valid (exc_valid_i),
        .exc_code  (exc_code_i),
        .irq_req   (irq_req_i),
        .icu_hit   (icu_hit_i),
        .kind      (kind),
        .eff_code  (eff_code)
    );

    exc_target #(.DATA_W(DATA_W), .CODE_W(CODE_W), .DSF_W(DSF_W)) u_tgt (
        .kind       (kind),
        .eff_code   (eff_code),
        .sr         (sr_i),
        .pc         (pc_i),
        .vbr        (vbr_i),
        .dsf        (dsf_i),
        .new_sr     (new_sr),
        .new_spc    (new_spc),
        .new_pc     (new_pc),
        .new_expevt (new_expevt)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (kind != KIND_NONE) state_d = ST_ENTRY;
            ST_ENTRY: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_o     <= DATA_W'(RESET_SR);
            ssr_o    <= '0;
            spc_o    <= '0;
            sgr_o    <= '0;
            expevt_o <= '0;
            intevt_o <= '0;
            pc_o     <= DATA_W'(RESET_PC);
            dsf_o    <= '0;
        end else if (kind != KIND_NONE) begin
            sr_o  <= new_sr;
            ssr_o <= sr_i;
            spc_o <= new_spc;
            sgr_o <= r15_i;
            pc_o  <= new_pc;
            dsf_o <= '0;
            if (kind == KIND_EXC) expevt_o <= new_expevt;
            if (kind == KIND_IRQ) intevt_o <= icu_code_i;
        end else begin
            dsf_o <= dsf_i;
        end
    end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 12,
    parameter int DSF_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_valid_i,
    input logic [CODE_W-1:0] exc_code_i,
    input logic              irq_req_i,
    input logic              icu_hit_i,
    input logic [DATA_W-1:0] sr_i,
    input logic [DATA_W-1:0] vbr_i,
    input logic              taken_o,
    input logic [DATA_W-1:0] sr_o,
    input logic [CODE_W-1:0] expevt_o,
    input logic [CODE_W-1:0] intevt_o,
    input logic [DATA_W-1:0] pc_o
);
    a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
        taken_o |=> !taken_o);

    a_r4_entry_bits: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_BL_BIT]));

    a_r1_exc_first: assert property (@(posedge clk) disable iff (rst)
        (!taken_o && exc_valid_i && irq_req_i) |=> $stable(intevt_o));

    a_r2_blocked_reset: assert property (@(posedge clk) disable iff (rst)
        (!taken_o && exc_valid_i && sr_i[SR_BL_BIT] && exc_code_i != CODE_W'(CODE_BREAK))
        |=> (pc_o == DATA_W'(RESET_PC) && expevt_o == '0));

    a_r3_blocked_irq: assert property (@(posedge clk) disable iff (rst)
        (!taken_o && !exc_valid_i && sr_i[SR_BL_BIT]) |=> !taken_o);

    a_r8_irq_entry: assert property (@(posedge clk) disable iff (rst)
        (!taken_o && !exc_valid_i && irq_req_i && icu_hit_i && !sr_i[SR_BL_BIT])
        |=> (taken_o && pc_o == $past(vbr_i) + DATA_W'(OFS_IRQ)));

    a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!taken_o && !exc_valid_i && !irq_req_i) |=> (!taken_o && $stable(pc_o)));

    a_r12_reset_state: assert property (@(posedge clk)
        rst |=> (pc_o == DATA_W'(RESET_PC) && sr_o == DATA_W'(RESET_SR) && !taken_o));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W), .DSF_W(DSF_W)) u_chk (.*);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
    localparam logic [31:0] PC0  = 32'h0C00_1000;
    localparam logic [31:0] VBR0 = 32'h8C00_0000;
    localparam logic [31:0] R150 = 32'h0C00_FFF0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic exc_valid_i = 0, irq_req_i = 0, icu_hit_i = 0;
    logic [11:0] exc_code_i = '0, icu_code_i = '0;
    logic [31:0] sr_i = '0, pc_i = PC0, vbr_i = VBR0, r15_i = R150;
    logic [1:0]  dsf_i = '0;
    logic [3:0]  irq_mask_o;
    logic        taken_o;
    logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;
    logic [1:0]  dsf_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (.*);

    typedef struct packed {
        logic        exc;  logic [11:0] code;
        logic        irq;  logic        hit;  logic [11:0] icode;
        logic [31:0] sr;   logic [1:0]  ds;
        logic        take; logic [31:0] pc;   logic [31:0] spc;
        logic [31:0] srx;  logic [11:0] ev;   logic [11:0] iev;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h0E0, 1'b0, 1'b0, 12'h000, 32'h0000_00A0, 2'b00, 1'b1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_00A0, 12'h0E0, 12'h000},
        '{1'b1, 12'h040, 1'b0, 1'b0, 12'h000, 32'h0000_00A0, 2'b00, 1'b1, 32'h8C00_0400, 32'h0C00_1000, 32'h7000_00A0, 12'h040, 12'h000},
        '{1'b1, 12'h060, 1'b0, 1'b0, 12'h000, 32'h0000_00A0, 2'b00, 1'b1, 32'h8C00_0400, 32'h0C00_1000, 32'h7000_00A0, 12'h060, 12'h000},
        '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 32'h0000_00A0, 2'b00, 1'b1, 32'h8C00_0100, 32'h0C00_1002, 32'h7000_00A0, 12'h160, 12'h000},
        '{1'b1, 12'h020, 1'b0, 1'b0, 12'h000, 32'h0000_00A0, 2'b00, 1'b1, 32'hA000_0000, 32'h0C00_1000, 32'h7000_00F0, 12'h020, 12'h000},
        '{1'b1, 12'h0E0, 1'b0, 1'b0, 12'h000, 32'h1000_00A0, 2'b00, 1'b1, 32'hA000_0000, 32'h0C00_1000, 32'h7000_00F0, 12'h000, 12'h000},
        '{1'b1, 12'h1E0, 1'b0, 1'b0, 12'h000, 32'h1000_00A0, 2'b00, 1'b1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_00A0, 12'h1E0, 12'h000},
        '{1'b1, 12'h8E0, 1'b0, 1'b0, 12'h000, 32'h0000_00A0, 2'b00, 1'b1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_00A0, 12'h0E0, 12'h000},
        '{1'b0, 12'h000, 1'b1, 1'b1, 12'h320, 32'h0000_00A0, 2'b00, 1'b1, 32'h8C00_0600, 32'h0C00_1000, 32'h7000_00A0, 12'h000, 12'h320},
        '{1'b1, 12'h0E0, 1'b1, 1'b1, 12'h320, 32'h0000_00A0, 2'b00, 1'b1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_00A0, 12'h0E0, 12'h000},
        '{1'b0, 12'h000, 1'b1, 1'b1, 12'h320, 32'h1000_00A0, 2'b00, 1'b0, 32'hA000_0000, 32'h0000_0000, 32'h7000_00F0, 12'h000, 12'h000},
        '{1'b0, 12'h000, 1'b1, 1'b0, 12'h320, 32'h0000_00A0, 2'b00, 1'b0, 32'hA000_0000, 32'h0000_0000, 32'h7000_00F0, 12'h000, 12'h000},
        '{1'b1, 12'h0E0, 1'b0, 1'b0, 12'h000, 32'h0000_00A0, 2'b01, 1'b1, 32'h8C00_0100, 32'h0C00_0FFE, 32'h7000_00A0, 12'h0E0, 12'h000},
        '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 32'h0000_00A0, 2'b10, 1'b1, 32'h8C00_0100, 32'h0C00_1000, 32'h7000_00A0, 12'h160, 12'h000}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 2: return "R7";
            3:       return "R9";
            4:       return "R6";
            5, 6:    return "R2";
            7:       return "R5";
            8:       return "R8";
            9:       return "R1";
            10, 11:  return "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        exc_valid_i = 0; irq_req_i = 0; icu_hit_i = 0;
        exc_code_i = '0; icu_code_i = '0; sr_i = '0;
        pc_i = PC0; vbr_i = VBR0; r15_i = R150; dsf_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<50000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12: reset state
        check("R12", "taken", 32'(taken_o), 32'd0);
        check("R12", "pc", pc_o, 32'hA000_0000);
        check("R12", "sr", sr_o, 32'h7000_00F0);
        check("R12", "expevt", 32'(expevt_o), 32'd0);
        check("R12", "spc", spc_o, 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            exc_valid_i = VECS[i].exc; exc_code_i = VECS[i].code;
            irq_req_i = VECS[i].irq; icu_hit_i = VECS[i].hit; icu_code_i = VECS[i].icode;
            sr_i = VECS[i].sr; dsf_i = VECS[i].ds;
            @(negedge clk);
            check(tag_of(i), "taken", 32'(taken_o), 32'(VECS[i].take));
            check(tag_of(i), "pc", pc_o, VECS[i].pc);
            check(tag_of(i), "spc", spc_o, VECS[i].spc);
            check(tag_of(i), "sr", sr_o, VECS[i].srx);
            check(tag_of(i), "expevt", 32'(expevt_o), 32'(VECS[i].ev));
            check(tag_of(i), "intevt", 32'(intevt_o), 32'(VECS[i].iev));
            // R4: saved status and R15
            check("R4", "ssr", ssr_o, VECS[i].take ? VECS[i].sr : 32'd0);
            check("R4", "sgr", sgr_o, VECS[i].take ? R150 : 32'd0);
            clear_inputs();
        end

        // R3: mask output follows status bits [7:4]
        sr_i = 32'h0000_00C0;
        #1 check("R3", "irq_mask", 32'(irq_mask_o), 32'hC);
        sr_i = 32'h0000_0030;
        #1 check("R3", "irq_mask", 32'(irq_mask_o), 32'h3);

        // R11: one-cycle strobe, requests during it ignored
        do_reset();
        exc_valid_i = 1; exc_code_i = 12'h0E0;
        @(negedge clk);
        check("R11", "taken first", 32'(taken_o), 32'd1);
        check("R11", "pc first", pc_o, 32'h8C00_0100);
        vbr_i = 32'h9000_0000;
        @(negedge clk);
        check("R11", "taken during entry", 32'(taken_o), 32'd0);
        check("R11", "pc held during entry", pc_o, 32'h8C00_0100);
        @(negedge clk);
        check("R11", "taken again", 32'(taken_o), 32'd1);
        check("R11", "pc second", pc_o, 32'h9000_0100);
        clear_inputs();

        // R13: idle cycles hold outputs
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R13", "taken idle", 32'(taken_o), 32'd0);
        check("R13", "pc idle", pc_o, 32'h9000_0100);
        check("R13", "expevt idle", 32'(expevt_o), 32'h0E0);

        // R10: flag tracking and clearing
        dsf_i = 2'b11;
        @(negedge clk);
        check("R10", "dsf follow", 32'(dsf_o), 32'h3);
        exc_valid_i = 1; exc_code_i = 12'h0E0;
        @(negedge clk);
        check("R10", "dsf cleared", 32'(dsf_o), 32'h0);
        check("R10", "spc rewind", spc_o, 32'h0C00_0FFE);
        clear_inputs();

        // R12: reset mid-run restores power-on state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12", "pc after rst", pc_o, 32'hA000_0000);
        check("R12", "sr after rst", sr_o, 32'h7000_00F0);
        check("R12", "expevt after rst", 32'(expevt_o), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule